// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter with four selectable analog inputs. Software picks a channel and starts a conversion through a small four-register bus. The block then waits for the next conversion-clock tick, closes the sample switch for a fixed number of ticks, and runs one bit trial per tick. Each trial puts a code on the DAC and keeps or drops the bit based on a single comparator bit. After a fixed tail the result is stored and a sticky interrupt flag is raised.

The conversion clock is a free-running divide-by-16 of the main clock, so the delay from a start write to the first tick is 1 to 16 main-clock cycles. The comparator, DAC and reference are outside the block. Channel 0 is always analog. Channels 1 to 3 share pins with a digital port, and their analog-enable bits reset to off.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, `irq_o`, `sample_o`, `dac_code_o` and `ch_sel_o` are 0, `ana_en_o` is 4'b0001, and registers 0, 2 and 3 read 00h.
- R2: Once a start is accepted, `sample_o` goes high on the next conversion-clock tick and stays high for exactly 5 tick periods (80 main-clock cycles).
- R3: From the clock edge that accepts a start to the edge that sets the interrupt flag there are 305 to 320 main-clock cycles (19 tick periods after the first tick).
- R4: Bits are tried MSB first, one per tick. The trial bit is kept when `cmp_i` is 1 (input at or above the trial code) and cleared otherwise. With an ideal comparator the stored result equals the input code, from 00h (lowest) to FFh (highest).
- R5: The first trial code on `dac_code_o`, present in the cycle after `sample_o` falls, is 80h. Outside the trial phase `dac_code_o` is 00h.
- R6: A write to register 0 while idle sets the channel from bits [1:0], and `ch_sel_o` shows it. A conversion starts only when bit 7 of that write is 1.
- R7: Register 1 holds the analog-enable bits of channels 1 to 3 in bits [3:1]. Bit 0 always reads 1, and `ana_en_o` mirrors bits [3:0].
- R8: A write to register 0 while busy is ignored completely. Neither the channel nor the timing of the running conversion changes.
- R9: Register 0 bit 6 reads 1 while a conversion is in progress and 0 otherwise.
- R10: The interrupt flag (register 3 bit 0, also `irq_o`) stays set until a write to register 3 with bit 0 at 1. A write with bit 0 at 0 leaves it set.
- R11: Register 2 (result) is read-only. It keeps its value until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ch_sel_o | output | 2 | Analog multiplexer channel select |
| ana_en_o | output | 4 | Per-channel analog-enable (bit 0 tied high) |
| sample_o | output | 1 | Sample switch control |
| dac_code_o | output | 8 | Trial code for the DAC |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial code |
| irq_o | output | 1 | Conversion-done interrupt request |

## Verification
The input codes 00h and FFh check that the bit loop reaches both ends of the range without wrapping. 80h and 7Fh differ in every bit, so they separate a correct MSB decision from an inverted or mis-ordered one. The alternating codes 55h and AAh, and 01h and FEh, expose swapped or stuck bit positions and a lost LSB trial. Every channel is converted with its own input code, so a wrong multiplexer select gives a wrong result. A second start during a busy conversion, aimed at a channel holding a different code, shows whether busy writes are really ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SAMPLE,
        ST_TRIAL,
        ST_TAIL
    } seq_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_AEN  = 2'd1;
    localparam logic [1:0] ADDR_RES  = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    localparam int CTRL_START_BIT = 7;
    localparam int CTRL_BUSY_BIT  = 6;
    localparam int BUS_W          = 8;

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == CW'(DIV-1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == CW'(DIV-1));

    // Ticks are isolated single-cycle pulses (R2 timing base)
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
#(
    parameter int RES_BITS     = 8,
    parameter int SAMPLE_TICKS = 5,
    parameter int CONV_TICKS   = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                start_i,
    input  logic                cmp_i,
    output logic                busy_o,
    output logic                sample_o,
    output logic [RES_BITS-1:0] trial_o,
    output logic [RES_BITS-1:0] acc_o,
    output logic                done_o
);
    localparam int TAIL_TICKS = CONV_TICKS - SAMPLE_TICKS - RES_BITS;
    localparam int CW         = $clog2(CONV_TICKS + 1);
    localparam int IW         = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
    localparam logic [RES_BITS-1:0] MSB_CODE = {1'b1, {(RES_BITS-1){1'b0}}};

    typedef struct packed {
        seq_state_e         st;
        logic [CW-1:0]      cnt;
        logic [IW-1:0]      idx;
        logic [RES_BITS-1:0] acc;
    } eng_t;

    eng_t d, q;
    logic [RES_BITS-1:0] bit_sel;

    always_comb begin
        bit_sel = RES_BITS'(1) << q.idx;
        d       = q;
        done_o  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st  = ST_ARM;
                    d.cnt = '0;
                end
            end
            ST_ARM: begin
                if (tick_i) begin
                    d.st  = ST_SAMPLE;
                    d.cnt = '0;
                end
            end
            ST_SAMPLE: begin
                if (tick_i) begin
                    if (q.cnt == CW'(SAMPLE_TICKS-1)) begin
                        d.st  = ST_TRIAL;
                        d.idx = IW'(RES_BITS-1);
                        d.acc = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_TRIAL: begin
                if (tick_i) begin
                    if (cmp_i) d.acc = q.acc | bit_sel;
                    if (q.idx == '0) begin
                        d.st  = ST_TAIL;
                        d.cnt = '0;
                    end else begin
                        d.idx = q.idx - 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (tick_i) begin
                    if (q.cnt == CW'(TAIL_TICKS-1)) begin
                        d.st   = ST_IDLE;
                        done_o = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.cnt <= '0;
            q.idx <= '0;
            q.acc <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.st != ST_IDLE);
    assign sample_o = (q.st == ST_SAMPLE);
    assign trial_o  = (q.st == ST_TRIAL) ? (q.acc | bit_sel) : '0;
    assign acc_o    = q.acc;

    // First trial after sampling carries only the MSB
    p_trial_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_o) |-> (trial_o == MSB_CODE));

    // Completion returns the sequencer to idle
    p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // Sampling only ever follows a tick-aligned entry, never from idle directly
    p_sample_from_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_o) |-> $past(tick_i));

endmodule

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int RES_BITS = 8,
    parameter int NCH      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [1:0]          addr_i,
    input  logic [BUS_W-1:0]    wdata_i,
    output logic [BUS_W-1:0]    rdata_o,
    input  logic                busy_i,
    input  logic                done_i,
    input  logic [RES_BITS-1:0] acc_i,
    output logic                start_o,
    output logic [$clog2(NCH)-1:0] ch_o,
    output logic [NCH-1:0]      aen_o,
    output logic                irq_o
);
    localparam int CSW = $clog2(NCH);

    typedef struct packed {
        logic [CSW-1:0]      ch;
        logic [NCH-1:1]      aen;
        logic [RES_BITS-1:0] res;
        logic                flag;
    } regs_t;

    regs_t d, q;
    logic  wr_ctrl, wr_aen, clr_flag;
    logic  unused_wbits;

    assign unused_wbits = ^wdata_i[5:4];

    assign wr_ctrl  = wr_i && (addr_i == ADDR_CTRL);
    assign wr_aen   = wr_i && (addr_i == ADDR_AEN);
    assign clr_flag = wr_i && (addr_i == ADDR_FLAG) && wdata_i[0];
    assign start_o  = wr_ctrl && !busy_i && wdata_i[CTRL_START_BIT];

    always_comb begin
        d = q;
        if (wr_ctrl && !busy_i) d.ch  = wdata_i[CSW-1:0];
        if (wr_aen)             d.aen = wdata_i[NCH-1:1];
        if (clr_flag)           d.flag = 1'b0;
        if (done_i) begin
            d.flag = 1'b1;
            d.res  = acc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ch   <= '0;
            q.aen  <= '0;
            q.res  <= '0;
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_CTRL: begin
                rdata_o[CSW-1:0]      = q.ch;
                rdata_o[CTRL_BUSY_BIT] = busy_i;
            end
            ADDR_AEN:  rdata_o[NCH-1:0] = {q.aen, 1'b1};
            ADDR_RES:  rdata_o[RES_BITS-1:0] = q.res;
            ADDR_FLAG: rdata_o[0] = q.flag;
            default:   rdata_o = '0;
        endcase
    end

    assign ch_o  = q.ch;
    assign aen_o = {q.aen, 1'b1};
    assign irq_o = q.flag;

    // Channel frozen while a conversion runs
    p_channel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(ch_o));

    // Flag survives everything but a write-one clear
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_flag) |=> irq_o);

    // Result only moves on completion
    p_result_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(q.res));

    // Flag rises only from a completion
    p_flag_from_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(done_i));

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_pkg::*;
#(
    parameter int DIV          = 16,
    parameter int NCH          = 4,
    parameter int RES_BITS     = 8,
    parameter int SAMPLE_TICKS = 5,
    parameter int CONV_TICKS   = 19
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [1:0]             bus_addr,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    output logic [$clog2(NCH)-1:0] ch_sel_o,
    output logic [NCH-1:0]         ana_en_o,
    output logic                   sample_o,
    output logic [RES_BITS-1:0]    dac_code_o,
    input  logic                   cmp_i,
    output logic                   irq_o
);
    logic                tick;
    logic                start;
    logic                busy;
    logic                done;
    logic [RES_BITS-1:0] acc;

    sar_prescaler #(.DIV(DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    sar_engine #(
        .RES_BITS     (RES_BITS),
        .SAMPLE_TICKS (SAMPLE_TICKS),
        .CONV_TICKS   (CONV_TICKS)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .start_i  (start),
        .cmp_i    (cmp_i),
        .busy_o   (busy),
        .sample_o (sample_o),
        .trial_o  (dac_code_o),
        .acc_o    (acc),
        .done_o   (done)
    );

    sar_regs #(
        .RES_BITS (RES_BITS),
        .NCH      (NCH)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .busy_i  (busy),
        .done_i  (done),
        .acc_i   (acc),
        .start_o (start),
        .ch_o    (ch_sel_o),
        .aen_o   (ana_en_o),
        .irq_o   (irq_o)
    );

endmodule

// File: tb/sar_adc_seq_test.sv
module sar_adc_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] ch_sel;
    logic [3:0] ana_en;
    logic       sample;
    logic [7:0] dac_code;
    logic       cmp;
    logic       irq;

    logic [7:0] vin [4];
    logic [7:0] exp_q [$];
    logic [7:0] last_res = 8'h00;
    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign cmp = (vin[ch_sel] >= dac_code);

    sar_adc_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ch_sel_o   (ch_sel),
        .ana_en_o   (ana_en),
        .sample_o   (sample),
        .dac_code_o (dac_code),
        .cmp_i      (cmp),
        .irq_o      (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // Driver: pushes the expected result, runs one conversion, compares timing
    task automatic run_conv(input int ch, input logic [7:0] v, input bit intrude);
        int ts, k, samp, lat;
        logic prev;
        logic [7:0] r;
        vin[ch] = v;
        exp_q.push_back(v);
        wr_reg(2'd0, 8'h80 | 8'(ch));
        ts = cyc; k = 0; samp = 0; prev = 1'b0;
        while (!irq && k < 1000) begin
            if (sample) samp++;
            if (prev && !sample)
                check(dac_code == 8'h80, "R5 first trial code", dac_code, 8'h80);
            prev = sample;
            if (k == 40) begin
                rd_reg(2'd0, r);
                check(r[6] == 1'b1, "R9 busy while converting", r, 8'h40);
                check(ch_sel == 2'(ch), "R6 channel select", ch_sel, ch);
                rd_reg(2'd2, r);
                check(r == last_res, "R11 result held mid-conversion", r, last_res);
            end
            if (intrude && k == 60) begin
                bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = (ch == 2) ? 8'h81 : 8'h82;
            end
            if (intrude && k == 61) begin
                bus_wr = 1'b0;
                check(ch_sel == 2'(ch), "R8 channel kept on busy write", ch_sel, ch);
            end
            @(negedge clk);
            k++;
        end
        lat = cyc - ts;
        check(k < 1000, "R3 conversion completes", k, 1000);
        check(lat >= 305 && lat <= 320, "R3 start-to-interrupt cycles", lat, 305);
        check(samp == 80, "R2 sample width", samp, 80);
        check(dac_code == 8'h00, "R5 code idle after trials", dac_code, 0);
        rd_reg(2'd0, r);
        check(r[6] == 1'b0, "R9 busy clear after done", r, 0);
        rd_reg(2'd2, r);
        // Monitor side of the scoreboard: oldest expectation first
        check(r == exp_q[0], "R4 result equals input code", r, exp_q[0]);
        void'(exp_q.pop_front());
        last_res = r;
    endtask

    task automatic clear_irq();
        check(irq == 1'b1, "R10 flag set after done", irq, 1);
        wr_reg(2'd3, 8'h00);
        repeat (10) @(negedge clk);
        check(irq == 1'b1, "R10 flag kept on zero write", irq, 1);
        wr_reg(2'd3, 8'h01);
        check(irq == 1'b0, "R10 flag cleared by one", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 4; i++) vin[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0, "R1 irq reset", irq, 0);
        check(sample == 1'b0, "R1 sample reset", sample, 0);
        check(dac_code == 8'h00, "R1 dac reset", dac_code, 0);
        check(ch_sel == 2'd0, "R1 channel reset", ch_sel, 0);
        check(ana_en == 4'b0001, "R1 analog enable reset", ana_en, 1);
        rd_reg(2'd0, r); check(r == 8'h00, "R1 ctrl reads zero", r, 0);
        rd_reg(2'd2, r); check(r == 8'h00, "R1 result reads zero", r, 0);
        rd_reg(2'd3, r); check(r == 8'h00, "R1 flag reads zero", r, 0);

        // R7 analog enable register
        rd_reg(2'd1, r); check(r == 8'h01, "R7 enable reset read", r, 1);
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1, r); check(r == 8'h0F, "R7 enable all", r, 8'h0F);
        check(ana_en == 4'b1111, "R7 enable pins all", ana_en, 4'hF);
        wr_reg(2'd1, 8'h04);
        rd_reg(2'd1, r); check(r == 8'h05, "R7 enable ch2 only", r, 8'h05);
        check(ana_en == 4'b0101, "R7 enable pins ch2", ana_en, 4'h5);

        // R11 result register ignores writes
        wr_reg(2'd2, 8'h5A);
        rd_reg(2'd2, r); check(r == 8'h00, "R11 result read-only", r, 0);

        // R4 pattern set across all channels
        run_conv(0, 8'h00, 1'b0); clear_irq();
        run_conv(1, 8'hFF, 1'b0); clear_irq();
        run_conv(2, 8'h80, 1'b0); clear_irq();
        run_conv(3, 8'h7F, 1'b0); clear_irq();
        run_conv(0, 8'h55, 1'b0); clear_irq();
        run_conv(1, 8'hAA, 1'b0); clear_irq();
        run_conv(2, 8'h01, 1'b0); clear_irq();
        run_conv(3, 8'hFE, 1'b0); clear_irq();

        // R8 busy write targets a channel with a different code
        vin[2] = 8'hC3;
        run_conv(0, 8'h3C, 1'b1); clear_irq();

        // R6 channel-only write while idle starts nothing
        wr_reg(2'd0, 8'h03);
        check(ch_sel == 2'd3, "R6 channel write idle", ch_sel, 3);
        repeat (400) @(negedge clk);
        check(irq == 1'b0, "R6 no conversion without start bit", irq, 0);
        rd_reg(2'd0, r); check(r == 8'h03, "R6 ctrl readback", r, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule